// File: doc/BRIEF.md
# Serial Receiver with Address-Frame Filtering

This block receives asynchronous serial frames on a single line and turns them into bytes held in a two-entry queue. A frame is one low start bit, eight data bits sent least significant first, an optional ninth slot and one stop bit. The ninth slot carries either a user extra bit or a parity bit. Timing comes from an external tick that runs at sixteen times the bit rate. Each queued entry keeps the byte together with one status bit. The status bit is the received extra bit when the extra-bit function is in use and parity is off. In every other case it is the received stop bit. Parity errors and queue overruns are reported through sticky flags.

On a shared bus, one sender addresses a group of listeners by sending a frame whose status bit is 1. When address filtering is on, the receiver keeps and signals only frames whose status bit is 1. Frames with a status bit of 0 are discarded and raise no interrupt. Software in a listener that recognises its address turns filtering off, so that the data frames which follow are accepted. Transmission and the comparison of addresses are done elsewhere.

Top module: `uart_mp_rx`

## Requirements
- R1: The idle line is high. A frame is a low start bit, eight data bits with the least significant bit first, a ninth slot present when `xbit_en_i` or `par_en_i` is 1, and a stop bit. Each bit is sampled near its middle, counted in `tick_i` pulses at 16 per bit.
- R2: Each accepted byte enters a first-in first-out queue. `rd_data_o` shows the oldest entry. A one-cycle `pop_i` removes that entry. `rd_valid_o` is 1 while the queue holds at least one entry.
- R3: When `xbit_en_i`=1 and `par_en_i`=0, the stored status bit that `rd_stat_o` shows is the received ninth bit.
- R4: In every other configuration, the stored status bit is the received stop bit.
- R5: When `par_en_i`=1, the ninth slot is compared with a parity value that `par_sel_i` selects: 0 gives odd parity (data plus parity has an odd count of ones), 1 gives even parity, 2 expects the bit to be 1 and 3 expects it to be 0. A mismatch sets `perr_o`. This holds for every completed frame, including frames that are filtered or dropped.
- R6: `perr_o` stays at 1 until a `perr_clr_i` pulse clears it. A frame with correct parity does not clear it.
- R7: The queue holds 2 entries. An accepted frame that arrives while the queue is full is dropped and the stored entries stay unchanged. The drop sets `ovr_o`, which stays at 1 until an `ovr_clr_i` pulse.
- R8: When `mp_en_i`=0, every completed frame produces a single one-cycle pulse on `irq_o`.
- R9: When `mp_en_i`=1, a frame whose status bit is 0 is discarded. It raises no interrupt, leaves the queue unchanged and cannot set `ovr_o`. A frame whose status bit is 1 is handled as in R8.
- R10: After reset, `rd_valid_o`, `perr_o`, `ovr_o` and `irq_o` are all 0.
- R11: A low pulse that is no longer low at the middle of the start bit is treated as noise. The receiver returns to idle and no frame results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial input line (asynchronous) |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| xbit_en_i | input | 1 | Frame carries a ninth slot used as an extra bit |
| par_en_i | input | 1 | Ninth slot carries parity and is checked |
| par_sel_i | input | 2 | Parity type: 0 odd, 1 even, 2 one, 3 zero |
| mp_en_i | input | 1 | Keep only frames whose status bit is 1 |
| pop_i | input | 1 | Remove the oldest queue entry |
| perr_clr_i | input | 1 | Clear the parity error flag |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 8 | Data byte of the oldest entry |
| rd_stat_o | output | 1 | Status bit of the oldest entry |
| rd_valid_o | output | 1 | Queue is not empty |
| perr_o | output | 1 | Sticky parity error flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The hardest case to reach is a data frame that is filtered out while the queue is already full. It must leave both entries and the overrun flag untouched, even though an unfiltered frame at the same moment would cause an overrun. The stimulus first fills the queue with two accepted frames and clears any overrun. It then turns filtering on and sends a frame whose status bit is 0, and it checks the flag, the interrupt count and the oldest entry. The random phase changes the parity type, the filtering and the ninth-slot settings between frames. It also flips parity bits and pops and clears at random, so that overruns and sticky errors pile up in mixed orders.

// File: rtl/uart_mp_rx.sv
module uart_mp_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          xbit_en_i,
  input  logic          par_en_i,
  input  logic [1:0]    par_sel_i,
  input  logic          mp_en_i,
  input  logic          pop_i,
  input  logic          perr_clr_i,
  input  logic          ovr_clr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_stat_o,
  output logic          rd_valid_o,
  output logic          perr_o,
  output logic          ovr_o,
  output logic          irq_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOP  = BW'(DW - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, SLOT, STOP} st_t;

  logic          s1, s2;
  st_t           st;
  logic [CW-1:0] ph;
  logic [BW-1:0] bn;
  logic [DW-1:0] sh;
  logic          slot_b, stop_b, done;
  logic [DW:0]   m0, m1;
  logic [1:0]    cnt;
  logic          par_exp;

  wire has_slot = xbit_en_i | par_en_i;
  wire stat     = (xbit_en_i & ~par_en_i) ? slot_b : stop_b;
  wire accept   = done & (~mp_en_i | stat);
  wire pop_ok   = pop_i & (cnt != 2'd0);
  wire push     = accept & ((cnt != 2'd2) | pop_ok);
  wire drop     = accept & ~push;
  wire bad_par  = done & par_en_i & (slot_b != par_exp);

  always_comb
    case (par_sel_i)
      2'd0:    par_exp = ~^sh;
      2'd1:    par_exp = ^sh;
      2'd2:    par_exp = 1'b1;
      default: par_exp = 1'b0;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      ph     <= '0;
      bn     <= '0;
      sh     <= '0;
      slot_b <= 1'b0;
      stop_b <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick_i) begin
        case (st)
          IDLE: if (!s2) begin
            st <= START;
            ph <= '0;
          end
          START: if (ph == MID) begin
            st <= s2 ? IDLE : DATA;
            ph <= '0;
            bn <= '0;
          end else ph <= ph + 1'b1;
          DATA: if (ph == LAST) begin
            ph <= '0;
            sh <= {s2, sh[DW-1:1]};
            if (bn == TOP) st <= has_slot ? SLOT : STOP;
            else bn <= bn + 1'b1;
          end else ph <= ph + 1'b1;
          SLOT: if (ph == LAST) begin
            ph     <= '0;
            slot_b <= s2;
            st     <= STOP;
          end else ph <= ph + 1'b1;
          STOP: if (ph == LAST) begin
            ph     <= '0;
            stop_b <= s2;
            done   <= 1'b1;
            st     <= IDLE;
          end else ph <= ph + 1'b1;
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m0  <= '0;
      m1  <= '0;
      cnt <= '0;
    end else begin
      case ({push, pop_ok})
        2'b10: begin
          if (cnt == 2'd0) m0 <= {stat, sh};
          else m1 <= {stat, sh};
          cnt <= cnt + 1'b1;
        end
        2'b01: begin
          m0  <= m1;
          cnt <= cnt - 1'b1;
        end
        2'b11: begin
          if (cnt == 2'd1) m0 <= {stat, sh};
          else begin
            m0 <= m1;
            m1 <= {stat, sh};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_o <= 1'b0;
      ovr_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      perr_o <= (perr_o & ~perr_clr_i) | bad_par;
      ovr_o  <= (ovr_o & ~ovr_clr_i) | drop;
      irq_o  <= accept;
    end
  end

  assign rd_data_o  = m0[DW-1:0];
  assign rd_stat_o  = m0[DW];
  assign rd_valid_o = cnt != 2'd0;
endmodule

// File: rtl/uart_mp_rx_chk.sv
module uart_mp_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       stat,
  input logic       mp_en_i,
  input logic       pop_i,
  input logic [1:0] cnt,
  input logic       irq_o,
  input logic       perr_o,
  input logic       perr_clr_i,
  input logic       ovr_o,
  input logic       ovr_clr_i
);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_irq_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(done));
  assert_filter_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_en_i && !stat) |=> !irq_o);
  assert_filter_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_en_i && !stat && !pop_i) |=> cnt == $past(cnt));
  assert_perr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o && !perr_clr_i) |=> perr_o);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);
endmodule

bind uart_mp_rx uart_mp_rx_chk chk (
  .clk(clk), .rst_n(rst_n), .done(done), .stat(stat), .mp_en_i(mp_en_i),
  .pop_i(pop_i), .cnt(cnt), .irq_o(irq_o), .perr_o(perr_o),
  .perr_clr_i(perr_clr_i), .ovr_o(ovr_o), .ovr_clr_i(ovr_clr_i)
);

// File: tb/uart_mp_rx_test.sv
`timescale 1ns/1ps
module uart_mp_rx_test;
  logic clk = 0, rst_n = 0, rx = 1, tick = 0;
  logic xen = 0, pen = 0, mpen = 0, pop = 0, pclr = 0, oclr = 0;
  logic [1:0] psel = 0;
  logic [7:0] rd_data;
  logic rd_stat, rd_valid, perr, ovr, irq;

  uart_mp_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .xbit_en_i(xen),
    .par_en_i(pen), .par_sel_i(psel), .mp_en_i(mpen), .pop_i(pop),
    .perr_clr_i(pclr), .ovr_clr_i(oclr), .rd_data_o(rd_data),
    .rd_stat_o(rd_stat), .rd_valid_o(rd_valid), .perr_o(perr), .ovr_o(ovr),
    .irq_o(irq)
  );

  always #2 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  int irq_cnt = 0;
  always @(posedge clk) if (irq) irq_cnt++;

  int nchk = 0, nfail = 0;
  bit fin = 0;
  logic [8:0] q[$];
  bit e_perr = 0, e_ovr = 0;
  int e_irq = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit par_of(logic [1:0] sel, logic [7:0] d);
    case (sel)
      2'd0: return ($countones(d) % 2) == 0;
      2'd1: return ($countones(d) % 2) == 1;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic verify();
    chk("R8/R9 irq count", irq_cnt, e_irq);
    chk("R5/R6 perr", perr, e_perr);
    chk("R7 ovr", ovr, e_ovr);
    chk("R2 valid", rd_valid, q.size() != 0);
    if (q.size() != 0) begin
      chk("R1/R2 head data", rd_data, q[0][7:0]);
      chk("R3/R4 head status", rd_stat, q[0][8]);
    end
  endtask

  task automatic send(logic [7:0] d, bit slot, bit hs);
    rx = 0; hold(32);
    for (int i = 0; i < 8; i++) begin rx = d[i]; hold(32); end
    if (hs) begin rx = slot; hold(32); end
    rx = 1; hold(40);
  endtask

  task automatic frame(logic [7:0] d, bit slot);
    bit hs = xen | pen;
    bit status = (xen && !pen) ? slot : 1'b1;
    bit acc = !mpen || status;
    send(d, slot, hs);
    if (pen && slot != par_of(psel, d)) e_perr = 1;
    if (acc) begin
      e_irq++;
      if (q.size() < 2) q.push_back({status, d});
      else e_ovr = 1;
    end
    verify();
  endtask

  task automatic do_pop();
    pop = 1; hold(1); pop = 0;
    if (q.size() != 0) void'(q.pop_front());
    hold(1);
    verify();
  endtask

  task automatic clr_perr();
    pclr = 1; hold(1); pclr = 0; e_perr = 0; hold(1); verify();
  endtask

  task automatic clr_ovr();
    oclr = 1; hold(1); oclr = 0; e_ovr = 0; hold(1); verify();
  endtask

  initial begin
    #(200000 * 4);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    hold(10); rst_n = 1; hold(4);
    chk("R10 valid", rd_valid, 0);
    chk("R10 perr", perr, 0);
    chk("R10 ovr", ovr, 0);
    chk("R10 irq", irq_cnt, 0);

    frame(8'hA5, 0);
    xen = 1; frame(8'h3C, 0);
    do_pop();
    frame(8'h81, 1);
    frame(8'h55, 1);
    chk("R7 head kept", rd_data, 8'h3C);
    do_pop(); do_pop(); clr_ovr();

    frame(8'h12, 1); frame(8'h34, 0); clr_ovr();
    mpen = 1; frame(8'h11, 0);
    chk("R9 no overrun", ovr, 0);
    frame(8'h99, 1);
    do_pop(); do_pop();
    frame(8'h22, 0); frame(8'h44, 1);
    mpen = 0; frame(8'h66, 0);
    do_pop(); do_pop();

    xen = 0; pen = 1;
    for (int s = 0; s < 4; s++) begin
      psel = 2'(s);
      frame(8'h5B, par_of(psel, 8'h5B));
      do_pop();
    end
    psel = 0; frame(8'h07, ~par_of(2'd0, 8'h07));
    psel = 1; frame(8'h70, par_of(2'd1, 8'h70));
    chk("R6 perr sticky", perr, 1);
    do_pop(); do_pop(); clr_perr();
    mpen = 1; frame(8'hE1, par_of(2'd1, 8'hE1)); do_pop();
    mpen = 0; pen = 0;

    rx = 0; hold(6); rx = 1; hold(80);
    chk("R11 false start irq", irq_cnt, e_irq);
    chk("R11 false start valid", rd_valid, 0);

    for (int n = 0; n < 150; n++) begin
      logic [7:0] d = 8'($urandom);
      bit slot;
      xen = 1'($urandom); pen = ($urandom % 3) == 0;
      psel = 2'($urandom); mpen = ($urandom % 3) == 0;
      if (pen) slot = (($urandom % 4) == 0) ? ~par_of(psel, d) : par_of(psel, d);
      else slot = 1'($urandom);
      frame(d, slot);
      if (($urandom % 10) < 6) do_pop();
      if (($urandom % 5) == 0) clr_perr();
      if (($urandom % 5) == 0) clr_ovr();
    end

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule